// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block turns the addressing fields of a decoded instruction into the effective address of its memory operand. It receives the 2-bit mode and 3-bit register/memory fields of the addressing byte, the scaled-index byte, the two register-extension bits that widen register numbers to four bits, a displacement already sign-extended to the address width, the instruction length and the current instruction pointer. Through two combinational read ports into a 16-entry general register file it fetches the base and index register values, then forms base + (index << scale) + displacement.

The special encodings are handled here. They are: instruction-pointer-relative addressing, the "no index" and "no base" encodings, the register operand form, and truncation to the address size. Outside 64-bit mode the block also flags registers that only exist in 64-bit mode, and addresses beyond a supplied segment limit. Along with the address, it reports which register should drive segment selection. The result is registered on an input strobe.

A two-state controller sequences the output. In ST_IDLE, a strobe moves to ST_SHOW (transition T_ACCEPT). In ST_SHOW, another strobe stays in ST_SHOW (T_CHAIN), and no strobe returns to ST_IDLE (T_RETIRE). `out_valid` is high exactly in ST_SHOW. Result registers load only on a strobe and otherwise hold.

Top module: `eagen_top`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high for the following cycle with the result of that request. Back-to-back strobes keep `out_valid` high with the newest result. Without a strobe, `out_valid` falls and `ea`, `ea_err` and `seg_sel` hold. After reset, `out_valid`=0, `ea`=0, `ea_err`=0 and `seg_sel`=16.
- R2: With `am_mod`=3 the operand is the register numbered {`rex_b`,`am_rm`}. `ea` is its value masked by `addr_size`: 0 keeps 16 bits, 1 keeps 32 bits, 2 keeps all 64. `seg_sel` is that register number.
- R3: `rex_b` adds 8 to the `am_rm` register number and to the scaled-index base field. `rex_x` adds 8 to the index field.
- R4: With `am_mod`=0 and `am_rm`=5, no register is read. In 64-bit mode (`long_mode`=1) the base is `ip` + `insn_len`; otherwise the base is 0. `seg_sel` is 16, meaning no register.
- R5: With `am_rm`=4 in a memory form, the scaled-index byte is used. Its bits [7:6] are the scale, [5:3] the index and [2:0] the base. `ea` = base + (index << scale) + `disp`, so the factor is 1, 2, 4 or 8. `seg_sel` is the base register number.
- R6: An extended index number of 4 adds no index term. Index number 12 (`rex_x`=1) is a real index.
- R7: A base field of 5 with `am_mod`=0 means no base, whatever `rex_b` is, and `seg_sel`=16. With `am_mod` of 1 or 2, the same field selects register 5, or 13 with `rex_b`.
- R8: With `addr_size`=1 the sum wraps modulo 2^32 and bits [63:32] of `ea` are 0. With `addr_size`=2 the full 64-bit sum is used.
- R9: Outside 64-bit mode, using a register numbered 8 or above sets `ea_err`.
- R10: Outside 64-bit mode, `ea_err` is set when `ea` is greater than the effective limit. That limit is `seg_limit` when `seg_gran`=0, and {`seg_limit`, 12 ones} when `seg_gran`=1. Equality is allowed. No limit check applies in 64-bit mode.
- R11: `ea_err` is also set in these cases: `addr_size`=3; `addr_size`=2 outside 64-bit mode; `addr_size`=0 with a memory form (`am_mod`≠3). Whenever `ea_err` is 1, `ea` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| am_mod | input | 2 | Mode field of the addressing byte |
| am_rm | input | 3 | Register/memory field of the addressing byte |
| sib | input | 8 | Scaled-index byte: scale [7:6], index [5:3], base [2:0] |
| rex_b | input | 1 | Extends the base/rm register number by 8 |
| rex_x | input | 1 | Extends the index register number by 8 |
| addr_size | input | 2 | 0: 16-bit, 1: 32-bit, 2: 64-bit, 3: reserved |
| long_mode | input | 1 | 64-bit mode active |
| disp | input | 64 | Sign-extended displacement |
| insn_len | input | 4 | Instruction length in bytes |
| ip | input | 64 | Current instruction pointer |
| seg_limit | input | 20 | Segment limit field |
| seg_gran | input | 1 | Limit counts 4 KiB pages |
| rf_base_num | output | 4 | Register file read address, base port |
| rf_base_val | input | 64 | Register file read data, base port |
| rf_index_num | output | 4 | Register file read address, index port |
| rf_index_val | input | 64 | Register file read data, index port |
| out_valid | output | 1 | Result valid, one cycle per strobe |
| ea | output | 64 | Effective address |
| seg_sel | output | 5 | Register for segment selection, 16 = none |
| ea_err | output | 1 | Request is invalid |

## Verification
The upper-register check (R9) and the limit comparison (R10) can both fail for the same request. A directed case outside 64-bit mode therefore names register 9 as base and also gives a small limit. A further case fails only the limit, so each source is judged alone: both must give `ea_err`=1 with `ea`=0. Consecutive strobes are also driven so that a capture coincides with the T_CHAIN transition. There the second result must replace the first while `out_valid` never drops.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    localparam int REG_NUM_W = 4;
    localparam int SEL_W     = 5;
    localparam int SEL_NONE  = 16;

    typedef enum logic [1:0] {
        ASZ_16  = 2'd0,
        ASZ_32  = 2'd1,
        ASZ_64  = 2'd2,
        ASZ_BAD = 2'd3
    } asz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ctl_st_e;

    typedef struct packed {
        logic             reg_form;
        logic             base_use;
        logic             base_is_ip;
        logic             idx_use;
        logic [1:0]       scale;
        logic             hi_reg;
        logic [SEL_W-1:0] seg_sel;
    } dec_t;

endpackage

// File: rtl/eagen_decode.sv
module eagen_decode
    import eagen_pkg::*;
(
    input  logic [1:0]           am_mod,
    input  logic [2:0]           am_rm,
    input  logic [7:0]           sib,
    input  logic                 rex_b,
    input  logic                 rex_x,
    output dec_t                 dec,
    output logic [REG_NUM_W-1:0] base_num,
    output logic [REG_NUM_W-1:0] idx_num
);

    always_comb begin
        dec         = '0;
        dec.seg_sel = SEL_W'(SEL_NONE);
        base_num    = {rex_b, am_rm};
        idx_num     = {rex_x, sib[5:3]};
        if (am_mod == 2'd3) begin
            dec.reg_form = 1'b1;
            dec.base_use = 1'b1;
            dec.seg_sel  = {1'b0, base_num};
            dec.hi_reg   = base_num[3];
        end else if (am_rm == 3'd4) begin
            dec.scale   = sib[7:6];
            dec.idx_use = (idx_num != 4'd4);
            if (!(am_mod == 2'd0 && sib[2:0] == 3'd5)) begin
                base_num     = {rex_b, sib[2:0]};
                dec.base_use = 1'b1;
                dec.seg_sel  = {1'b0, base_num};
            end
            dec.hi_reg = (dec.idx_use & idx_num[3]) | (dec.base_use & base_num[3]);
        end else if (am_mod == 2'd0 && am_rm == 3'd5) begin
            dec.base_is_ip = 1'b1;
        end else begin
            dec.base_use = 1'b1;
            dec.seg_sel  = {1'b0, base_num};
            dec.hi_reg   = base_num[3];
        end
    end

endmodule

// File: rtl/eagen_sum.sv
module eagen_sum
    import eagen_pkg::*;
#(
    parameter int AW    = 64,
    parameter int LEN_W = 4
) (
    input  dec_t             dec,
    input  logic [AW-1:0]    base_val,
    input  logic [AW-1:0]    idx_val,
    input  logic [AW-1:0]    disp,
    input  logic [AW-1:0]    ip,
    input  logic [LEN_W-1:0] insn_len,
    input  logic             long_mode,
    input  asz_e             asz,
    output logic [AW-1:0]    ea_raw
);

    localparam logic [AW-1:0] MASK16 = AW'({16{1'b1}});
    localparam logic [AW-1:0] MASK32 = AW'({32{1'b1}});

    logic [AW-1:0] base_term;
    logic [AW-1:0] idx_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] total;

    always_comb begin
        if (dec.base_use)
            base_term = base_val;
        else if (dec.base_is_ip && long_mode)
            base_term = ip + AW'(insn_len);
        else
            base_term = '0;
        idx_term  = dec.idx_use ? (idx_val << dec.scale) : '0;
        disp_term = dec.reg_form ? '0 : disp;
        total     = base_term + idx_term + disp_term;
        unique case (asz)
            ASZ_16:  ea_raw = total & MASK16;
            ASZ_32:  ea_raw = total & MASK32;
            default: ea_raw = total;
        endcase
    end

endmodule

// File: rtl/eagen_limit.sv
module eagen_limit #(
    parameter int AW      = 64,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12
) (
    input  logic [AW-1:0]    ea_raw,
    input  logic [LIM_W-1:0] seg_limit,
    input  logic             seg_gran,
    output logic             over
);

    localparam int EFF_W = LIM_W + GRAN_SH;

    logic [EFF_W-1:0] eff_lim;

    always_comb begin
        eff_lim = seg_gran ? {seg_limit, {GRAN_SH{1'b1}}}
                           : {{GRAN_SH{1'b0}}, seg_limit};
        over    = (ea_raw > AW'(eff_lim));
    end

endmodule

// File: rtl/eagen_top.sv
module eagen_top
    import eagen_pkg::*;
#(
    parameter int AW      = 64,
    parameter int LEN_W   = 4,
    parameter int LIM_W   = 20,
    parameter int GRAN_SH = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           am_mod,
    input  logic [2:0]           am_rm,
    input  logic [7:0]           sib,
    input  logic                 rex_b,
    input  logic                 rex_x,
    input  logic [1:0]           addr_size,
    input  logic                 long_mode,
    input  logic [AW-1:0]        disp,
    input  logic [LEN_W-1:0]     insn_len,
    input  logic [AW-1:0]        ip,
    input  logic [LIM_W-1:0]     seg_limit,
    input  logic                 seg_gran,
    output logic [REG_NUM_W-1:0] rf_base_num,
    input  logic [AW-1:0]        rf_base_val,
    output logic [REG_NUM_W-1:0] rf_index_num,
    input  logic [AW-1:0]        rf_index_val,
    output logic                 out_valid,
    output logic [AW-1:0]        ea,
    output logic [SEL_W-1:0]     seg_sel,
    output logic                 ea_err
);

    dec_t          dec;
    asz_e          asz;
    logic [AW-1:0] ea_raw;
    logic          over;
    logic          err_c;
    ctl_st_e       st_q;
    ctl_st_e       st_d;

    assign asz = asz_e'(addr_size);

    eagen_decode u_decode (
        .am_mod   (am_mod),
        .am_rm    (am_rm),
        .sib      (sib),
        .rex_b    (rex_b),
        .rex_x    (rex_x),
        .dec      (dec),
        .base_num (rf_base_num),
        .idx_num  (rf_index_num)
    );

    eagen_sum #(.AW(AW), .LEN_W(LEN_W)) u_sum (
        .dec       (dec),
        .base_val  (rf_base_val),
        .idx_val   (rf_index_val),
        .disp      (disp),
        .ip        (ip),
        .insn_len  (insn_len),
        .long_mode (long_mode),
        .asz       (asz),
        .ea_raw    (ea_raw)
    );

    eagen_limit #(.AW(AW), .LIM_W(LIM_W), .GRAN_SH(GRAN_SH)) u_limit (
        .ea_raw    (ea_raw),
        .seg_limit (seg_limit),
        .seg_gran  (seg_gran),
        .over      (over)
    );

    always_comb begin
        err_c = (asz == ASZ_BAD)
              | (!long_mode && asz == ASZ_64)
              | (!dec.reg_form && asz == ASZ_16)
              | (!long_mode && dec.hi_reg)
              | (!long_mode && over);
    end

    // Next-state logic: T_ACCEPT, T_CHAIN, T_RETIRE
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: st_d = in_valid ? ST_SHOW : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ea      <= '0;
            ea_err  <= 1'b0;
            seg_sel <= SEL_W'(SEL_NONE);
        end else if (in_valid) begin
            ea      <= err_c ? '0 : ea_raw;
            ea_err  <= err_c;
            seg_sel <= dec.seg_sel;
        end
    end

    always_comb out_valid = (st_q == ST_SHOW);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_reg_seg_r2: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && am_mod == 2'd3) |-> seg_sel == {1'b0, $past(rex_b), $past(am_rm)});

    p_ip_rel_seg_r4: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && am_mod == 2'd0 && am_rm == 3'd5) |-> seg_sel == SEL_W'(SEL_NONE));

    p_addr32_upper_r8: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && addr_size == 2'd1) |-> ea[AW-1:32] == '0);

    p_hireg_err_r9: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !long_mode && dec.hi_reg) |-> ea_err);

    p_err_blanks_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ea_err) |-> ea == '0);

endmodule

// File: tb/eagen_top_tb_top.sv
module eagen_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  b_mod = '0;
    logic [2:0]  b_rm = '0;
    logic [7:0]  b_sib = '0;
    logic        b_rb = 1'b0;
    logic        b_rx = 1'b0;
    logic [1:0]  b_asz = 2'd2;
    logic        b_lm = 1'b1;
    logic [63:0] b_disp = '0;
    logic [3:0]  b_len = 4'd1;
    logic [63:0] b_ip = '0;
    logic [19:0] b_lim = 20'hfffff;
    logic        b_gran = 1'b1;
    logic [3:0]  rf_bn, rf_in;
    logic [63:0] rf [16];
    logic [63:0] rf_bv, rf_iv;
    logic        out_valid;
    logic [63:0] ea;
    logic [4:0]  seg_sel;
    logic        ea_err;
    int          total = 0;
    int          bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_bv = rf[rf_bn];
    assign rf_iv = rf[rf_in];

    eagen_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .am_mod(b_mod), .am_rm(b_rm), .sib(b_sib), .rex_b(b_rb), .rex_x(b_rx),
        .addr_size(b_asz), .long_mode(b_lm), .disp(b_disp), .insn_len(b_len),
        .ip(b_ip), .seg_limit(b_lim), .seg_gran(b_gran),
        .rf_base_num(rf_bn), .rf_base_val(rf_bv),
        .rf_index_num(rf_in), .rf_index_val(rf_iv),
        .out_valid(out_valid), .ea(ea), .seg_sel(seg_sel), .ea_err(ea_err)
    );

    function automatic void model(output logic [63:0] e, output logic er, output logic [4:0] s);
        logic [63:0] base, idx, sum, lim;
        logic [3:0]  br, ix;
        logic        hi;
        base = 0; idx = 0; hi = 0; er = 0; s = 5'd16;
        if (b_asz == 2'd3) er = 1;
        if (!b_lm && b_asz == 2'd2) er = 1;
        if (b_mod == 2'd3) begin
            br = {b_rb, b_rm}; s = {1'b0, br}; hi = br[3];
            sum = rf[br];
        end else begin
            if (b_asz == 2'd0) er = 1;
            if (b_rm == 3'd4) begin
                ix = {b_rx, b_sib[5:3]};
                if (ix != 4'd4) begin idx = rf[ix] << b_sib[7:6]; hi = hi | ix[3]; end
                if (!(b_mod == 2'd0 && b_sib[2:0] == 3'd5)) begin
                    br = {b_rb, b_sib[2:0]}; base = rf[br]; s = {1'b0, br}; hi = hi | br[3];
                end
            end else if (b_mod == 2'd0 && b_rm == 3'd5) begin
                base = b_lm ? b_ip + {60'd0, b_len} : 64'd0;
            end else begin
                br = {b_rb, b_rm}; base = rf[br]; s = {1'b0, br}; hi = br[3];
            end
            sum = base + idx + b_disp;
        end
        if (b_asz == 2'd0)      sum = {48'd0, sum[15:0]};
        else if (b_asz == 2'd1) sum = {32'd0, sum[31:0]};
        if (!b_lm && hi) er = 1;
        lim = b_gran ? {32'd0, b_lim, 12'hfff} : {44'd0, b_lim};
        if (!b_lm && sum > lim) er = 1;
        e = er ? 64'd0 : sum;
    endfunction

    task automatic chk(input string tag, input logic [63:0] xe, input logic xer, input logic [4:0] xs);
        total++;
        if (ea !== xe || ea_err !== xer || seg_sel !== xs || out_valid !== 1'b1) begin
            bad++;
            $display("FAIL %s ea=%h exp %h err=%0b exp %0b seg=%0d exp %0d vld=%0b exp 1",
                     tag, ea, xe, ea_err, xer, seg_sel, xs, out_valid);
        end
    endtask

    task automatic fire;
        @(negedge clk); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic set_req(input logic [1:0] m, input logic [2:0] r, input logic [7:0] sb,
                           input logic rb, input logic rx, input logic [1:0] az, input logic lm);
        b_mod = m; b_rm = r; b_sib = sb; b_rb = rb; b_rx = rx; b_asz = az; b_lm = lm;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] xe; logic xer; logic [4:0] xs;
        for (int i = 0; i < 16; i++) rf[i] = {32'h1000_0000 + 32'(i), 32'h0000_0100 * 32'(i + 1)};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || ea !== 64'd0 || ea_err !== 1'b0 || seg_sel !== 5'd16) begin
            bad++;
            $display("FAIL R1 reset vld=%0b ea=%h err=%0b seg=%0d exp 0/0/0/16", out_valid, ea, ea_err, seg_sel);
        end

        // R2: register form masked to 16 bits
        rf[3] = 64'h1234_5678_9abc_def0;
        set_req(2'd3, 3'd3, 8'd0, 0, 0, 2'd0, 1); fire();
        chk("R2 reg form 16b", 64'h0000_0000_0000_def0, 0, 5'd3);
        set_req(2'd3, 3'd3, 8'd0, 0, 0, 2'd1, 1); fire();
        chk("R2 reg form 32b", 64'h0000_0000_9abc_def0, 0, 5'd3);

        // R3: rex_b on register form
        rf[9] = 64'hfeed_0000_0000_0009;
        set_req(2'd3, 3'd1, 8'd0, 1, 0, 2'd2, 1); fire();
        chk("R3 rex_b reg 9", 64'hfeed_0000_0000_0009, 0, 5'd9);

        // R4: instruction-pointer relative and absolute
        b_ip = 64'h0000_7000_0000_1000; b_len = 4'd6; b_disp = 64'h20;
        set_req(2'd0, 3'd5, 8'd0, 0, 0, 2'd2, 1); fire();
        chk("R4 ip relative", 64'h0000_7000_0000_1026, 0, 5'd16);
        b_lim = 20'hfffff; b_gran = 1;
        set_req(2'd0, 3'd5, 8'd0, 0, 0, 2'd1, 0); fire();
        chk("R4 absolute legacy", 64'h20, 0, 5'd16);

        // R5: scaled index, factor 8, negative displacement
        rf[1] = 64'h0000_0001_0000_0000; rf[2] = 64'h10; b_disp = 64'hffff_ffff_ffff_fff8;
        set_req(2'd2, 3'd4, {2'd3, 3'd2, 3'd1}, 0, 0, 2'd2, 1); fire();
        chk("R5 scale 8", 64'h0000_0001_0000_0078, 0, 5'd1);

        // R6: index 4 means none; index 12 is used
        rf[4] = 64'h5555; rf[12] = 64'h3; b_disp = 64'd0;
        set_req(2'd1, 3'd4, {2'd1, 3'd4, 3'd1}, 0, 0, 2'd2, 1); fire();
        chk("R6 no index", 64'h0000_0001_0000_0000, 0, 5'd1);
        set_req(2'd1, 3'd4, {2'd1, 3'd4, 3'd1}, 0, 1, 2'd2, 1); fire();
        chk("R6 index 12", 64'h0000_0001_0000_0006, 0, 5'd1);

        // R7: base 5 with mod 0 is none even with rex_b; mod 1 gives reg 13
        rf[13] = 64'h0000_0000_00ab_0000; b_disp = 64'h44;
        set_req(2'd0, 3'd4, {2'd0, 3'd4, 3'd5}, 1, 0, 2'd2, 1); fire();
        chk("R7 no base", 64'h44, 0, 5'd16);
        set_req(2'd1, 3'd4, {2'd0, 3'd4, 3'd5}, 1, 0, 2'd2, 1); fire();
        chk("R7 base 13", 64'h0000_0000_00ab_0044, 0, 5'd13);

        // R8: 32-bit wrap versus 64-bit carry
        rf[0] = 64'hffff_ffff_ffff_fff0; b_disp = 64'h20;
        set_req(2'd2, 3'd0, 8'd0, 0, 0, 2'd1, 1); fire();
        chk("R8 wrap 32", 64'h10, 0, 5'd0);
        set_req(2'd2, 3'd0, 8'd0, 0, 0, 2'd2, 1); fire();
        chk("R8 full 64", 64'h10, 0, 5'd0);
        rf[0] = 64'h0000_0000_ffff_fff0;
        set_req(2'd2, 3'd0, 8'd0, 0, 0, 2'd2, 1); fire();
        chk("R8 carry 64", 64'h0000_0001_0000_0010, 0, 5'd0);

        // R9: upper register outside 64-bit mode
        set_req(2'd3, 3'd1, 8'd0, 1, 0, 2'd1, 0); fire();
        chk("R9 reg 9 legacy", 64'd0, 1, 5'd9);

        // R10: limit boundaries
        b_disp = 64'h1000; b_lim = 20'h00fff; b_gran = 0;
        set_req(2'd0, 3'd5, 8'd0, 0, 0, 2'd1, 0); fire();
        chk("R10 over byte limit", 64'd0, 1, 5'd16);
        b_disp = 64'hfff; b_lim = 20'h0; b_gran = 1; fire();
        chk("R10 equal page limit", 64'hfff, 0, 5'd16);
        b_disp = 64'h1000; fire();
        chk("R10 over page limit", 64'd0, 1, 5'd16);
        b_lm = 1'b1; b_asz = 2'd2; b_disp = 64'h1000_0000; b_ip = 64'd0; b_len = 4'd0; fire();
        chk("R10 no limit in long", 64'h1000_0000, 0, 5'd16);

        // R9 with R10 in one request
        rf[9] = 64'h10; b_disp = 64'h2000; b_lim = 20'h0; b_gran = 1;
        set_req(2'd2, 3'd1, 8'd0, 1, 0, 2'd1, 0); fire();
        chk("R9 R10 together", 64'd0, 1, 5'd9);

        // R11: invalid size combinations
        b_lim = 20'hfffff; b_gran = 1; b_disp = 64'h8;
        set_req(2'd1, 3'd0, 8'd0, 0, 0, 2'd0, 1); fire();
        chk("R11 16b memory", 64'd0, 1, 5'd0);
        set_req(2'd1, 3'd0, 8'd0, 0, 0, 2'd2, 0); fire();
        chk("R11 64b legacy", 64'd0, 1, 5'd0);
        set_req(2'd1, 3'd0, 8'd0, 0, 0, 2'd3, 1); fire();
        chk("R11 reserved size", 64'd0, 1, 5'd0);

        // R1: back-to-back strobes, then hold
        rf[6] = 64'h600; rf[7] = 64'h700; b_disp = 64'h1;
        @(negedge clk); set_req(2'd1, 3'd6, 8'd0, 0, 0, 2'd2, 1); in_valid = 1'b1;
        @(negedge clk); chk("R1 first of pair", 64'h601, 0, 5'd6);
        set_req(2'd1, 3'd7, 8'd0, 0, 0, 2'd2, 1);
        @(negedge clk); chk("R1 second of pair", 64'h701, 0, 5'd7);
        in_valid = 1'b0; b_rm = 3'd6;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || ea !== 64'h701 || seg_sel !== 5'd7) begin
            bad++;
            $display("FAIL R1 hold vld=%0b ea=%h seg=%0d exp 0/701/7", out_valid, ea, seg_sel);
        end

        // Random mix checked against the model
        void'($urandom(32'd2718));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            if (n % 16 == 0)
                for (int k = 0; k < 16; k++) rf[k] = {$urandom, $urandom};
            r = $urandom;
            b_lm = r[0];
            b_mod = r[2:1]; b_rm = r[5:3]; b_sib = r[13:6];
            b_rb = b_lm ? r[14] : (r[16:14] == 3'd0);
            b_rx = b_lm ? r[15] : (r[19:17] == 3'd0);
            if (r[22:20] == 3'd0)  b_asz = r[24:23];
            else if (b_lm)         b_asz = r[23] ? 2'd2 : 2'd1;
            else                   b_asz = 2'd1;
            r = $urandom;
            b_disp = {{32{r[31]}}, r};
            b_len = 4'(1 + ($urandom % 15));
            b_ip = {$urandom, $urandom};
            r = $urandom;
            if (r[1:0] == 2'd0) begin b_lim = r[21:2]; b_gran = r[22]; end
            else begin b_lim = 20'hfffff; b_gran = 1'b1; end
            model(xe, xer, xs);
            fire();
            chk("random mix", xe, xer, xs);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule